// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a clocked host to an external asynchronous static RAM of 262,144 sixteen-bit words. The host raises a one-cycle request with a direction flag, an 18-bit word address, write data and a two-bit lane mask. The controller then runs a single access on the memory pins and answers with a one-cycle completion pulse. On a read, the returned word comes with that pulse.

The memory interface has the usual active-low controls: chip select, output enable, write strobe and one select per byte lane. The data bus is split into outgoing data, an incoming sample and a drive-enable, so that the pad ring can build the bidirectional pin. The read access, the write pulse and the idle gap after each access are each held for a whole number of clock cycles. These counts are worked out at elaboration from nanosecond timings and the clock period.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write strobe and both lane selects are high (inactive), the data drive-enable is low, and the completion pulse is low.
- R2: During a read, chip select and output enable are low, the write strobe is high, and the data drive-enable is low. The read phase lasts exactly RD_CYC = max(1, ceil(T_RD_NS/CLK_NS)) cycles.
- R3: During a write, chip select and the write strobe are low and output enable is high. The drive-enable is high, and the outgoing data equals the request's write data. The write phase lasts exactly WR_CYC = max(1, ceil(T_WP_NS/CLK_NS)) cycles, and the drive-enable is never high unless the write strobe is low.
- R4: Mask bit 0 controls the lower lane select (data bits 7..0), and mask bit 1 controls the upper lane select (bits 15..8). A lane select is low during an access exactly when its mask bit is 1, and a write with a mask bit at 0 leaves that byte of memory unchanged.
- R5: Read data is sampled on the clock edge that ends the read phase. It is presented on the read-data output in the same cycle as the one-cycle completion pulse. A lane whose mask bit is 0 reads back as 0x00.
- R6: A write ends with a one-cycle completion pulse, which appears in the first cycle after the write phase.
- R7: Every access is followed by REC_CYC = max(1, ceil(T_REC_NS/CLK_NS)) cycles with chip select high and the bus released. After that the controller accepts a new request at once.
- R8: A request that arrives while an access or gap is in progress is ignored. It does not change the memory address pins, the memory contents, or the number of completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done on a read |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_o | output | 16 | Outgoing data |
| mem_dq_oe | output | 1 | Data drive-enable |
| mem_dq_i | input | 16 | Incoming data from the memory |

## Verification
Reads are tried with each lane mask: both lanes, lower only and upper only. The memory model drives a filler pattern on unselected lanes, so a select wired to the wrong lane, or a missing zero mask, shows up in the returned word. Partial writes are read back with both lanes selected, which separates a correct byte merge from a full-word overwrite. The strobes are sampled in every cycle of every phase, which separates correct phase lengths from lengths that are off by one. Back-to-back requests, and a request raised in the middle of a read, tell a correctly idle-gated accept apart from one that restarts or chains accesses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_READ    = 2'd1,
        PH_WRITE   = 2'd2,
        PH_RECOVER = 2'd3
    } phase_t;

    typedef struct packed {
        logic [17:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
    } access_t;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_ctrl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  phase_t           phase,
    input  logic [LANES-1:0] be,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             drive
);
    always_comb begin
        ce_n   = 1'b1;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        lane_n = '1;
        drive  = 1'b0;
        unique case (phase)
            PH_READ: begin
                ce_n   = 1'b0;
                oe_n   = 1'b0;
                lane_n = ~be;
            end
            PH_WRITE: begin
                ce_n   = 1'b0;
                we_n   = 1'b0;
                lane_n = ~be;
                drive  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 20,
    parameter int T_RD_NS  = 10,
    parameter int T_WP_NS  = 8,
    parameter int T_REC_NS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        req_wr,
    input  logic [17:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        done,
    output logic [15:0] rdata,
    output logic [17:0] mem_addr,
    output logic        mem_ce_n,
    output logic        mem_oe_n,
    output logic        mem_we_n,
    output logic        mem_lb_n,
    output logic        mem_ub_n,
    output logic [15:0] mem_dq_o,
    output logic        mem_dq_oe,
    input  logic [15:0] mem_dq_i
);
    localparam int DW      = 16;
    localparam int LANES   = DW / 8;
    localparam int RD_CYC  = ns_to_cycles(T_RD_NS, CLK_NS);
    localparam int WR_CYC  = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int REC_CYC = ns_to_cycles(T_REC_NS, CLK_NS);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC)
                                               : ((WR_CYC > REC_CYC) ? WR_CYC : REC_CYC);
    localparam int TW      = $clog2(MAX_CYC + 1);

    phase_t          phase;
    access_t         acc;
    logic            t_load, t_zero;
    logic [TW-1:0]   t_val;
    logic [LANES-1:0] lane_n;
    logic [DW-1:0]   lane_mask;

    sram_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (phase)
            PH_IDLE: begin
                t_load = req;
                t_val  = req_wr ? TW'(WR_CYC - 1) : TW'(RD_CYC - 1);
            end
            PH_READ, PH_WRITE: begin
                t_load = t_zero;
                t_val  = TW'(REC_CYC - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            acc   <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (req) begin
                    phase <= req_wr ? PH_WRITE : PH_READ;
                    acc   <= '{addr: req_addr, wdata: req_wdata, be: req_be};
                end
                PH_READ: if (t_zero) begin
                    rdata <= mem_dq_i & lane_mask;
                    done  <= 1'b1;
                    phase <= PH_RECOVER;
                end
                PH_WRITE: if (t_zero) begin
                    done  <= 1'b1;
                    phase <= PH_RECOVER;
                end
                PH_RECOVER: if (t_zero) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{acc.be[g]}};
    end

    sram_strobe_gen #(.LANES(LANES)) u_strobe (
        .phase(phase), .be(acc.be),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .lane_n(lane_n), .drive(mem_dq_oe)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];
    assign mem_addr = acc.addr;
    assign mem_dq_o = acc.wdata;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [17:0] mem_addr,
    input logic        mem_ce_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        mem_dq_oe
);
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R3

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_ce_n && !mem_dq_oe)); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
    localparam int RD  = 3;  // 50 ns / 20 ns
    localparam int WR  = 2;  // 40 ns / 20 ns
    localparam int REC = 2;  // 30 ns / 20 ns

    logic        clk = 1'b0, rst = 1'b1;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        done;
    logic [15:0] rdata, mem_dq_o, mem_dq_i;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] mdl [256];

    always #10 clk = ~clk;

    sram_async_ctrl #(.CLK_NS(20), .T_RD_NS(50), .T_WP_NS(40), .T_REC_NS(30)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model: unselected lanes show a filler byte
    always_comb begin
        mem_dq_i = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_i[7:0]  = mdl[mem_addr[7:0]][7:0];
            if (!mem_ub_n) mem_dq_i[15:8] = mdl[mem_addr[7:0]][15:8];
        end
    end
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic gap_check();
        for (int i = 0; i < REC; i++) begin
            chk("R7 gap ce_n/oe", {mem_ce_n, mem_dq_oe}, 2'b10);
            if (i > 0) chk("R5/R6 done single", done, 0);
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] be, input logic [15:0] exp,
                           input logic busy_poke);
        issue(1'b0, a, 16'h0, be);
        for (int i = 0; i < RD; i++) begin
            chk("R2 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
            chk("R4 read lanes", {mem_ub_n, mem_lb_n}, {~be[1], ~be[0]});
            chk("R8 addr held", mem_addr, a);
            chk("R5 no early done", done, 0);
            if (busy_poke && i == 0) begin
                req = 1'b1; req_wr = 1'b1; req_addr = a ^ 18'h5; req_wdata = 16'hFFFF; req_be = 2'b11;
            end else req = 1'b0;
            @(negedge clk);
        end
        req = 1'b0;
        chk("R5 done", done, 1);
        chk("R5 rdata", rdata, exp);
        gap_check();
        chk("R8 no restart", {mem_ce_n, done}, 2'b10);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        issue(1'b1, a, d, be);
        for (int i = 0; i < WR; i++) begin
            chk("R3 write strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
            chk("R3 write data", mem_dq_o, d);
            chk("R4 write lanes", {mem_ub_n, mem_lb_n}, {~be[1], ~be[0]});
            chk("R6 no early done", done, 0);
            @(negedge clk);
        end
        chk("R6 write done", done, 1);
        gap_check();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 16'(i * 16'h0101) ^ 16'h3C00;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, done}, 7'b1111100);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {mem_ce_n, mem_dq_oe, done}, 3'b100);
        // R2/R5: full-word read
        do_read(18'h00010, 2'b11, 16'h3C00 ^ 16'h1010, 1'b0);
        // R4/R5: single-lane reads, unselected lane returns zero
        do_read(18'h00022, 2'b01, 16'h0022, 1'b0);
        do_read(18'h00022, 2'b10, 16'h1E00, 1'b0);
        // R3/R6: full write, then back-to-back read (R7 accept right after gap)
        do_write(18'h00040, 16'hBEEF, 2'b11);
        do_read(18'h00040, 2'b11, 16'hBEEF, 1'b0);
        // R4: partial writes keep the other byte
        do_write(18'h00041, 16'h1234, 2'b01);
        do_read(18'h00041, 2'b11, 16'h7D34, 1'b0);
        do_write(18'h00042, 16'h9876, 2'b10);
        do_read(18'h00042, 2'b11, 16'h9842, 1'b0);
        // R8: write request during a read is ignored
        do_read(18'h00050, 2'b11, 16'h6C50, 1'b1);
        do_read(18'h00055, 2'b11, 16'h6955, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule